// File: doc/BRIEF.md
# Frame-Sync Width Mode Selector

This block watches the frame-sync line of each channel direction of a speech compression engine and decides, sample by sample, which compression algorithm that channel should run. Each sample opens with a sync pulse on its channel. At the start of that pulse the block captures the algorithm code that the control register holds for the channel. While the pulse is high, the block counts bit clocks.

When the captured code selects 32 kbps and the pulse lasts two bit clocks or longer, the block runs that sample at 24 kbps instead. At 24 kbps the least significant bit of each output code word carries no speech, so a signalling bit from a separate input is put into that bit position. In every other mode the pulse width plays no part in the decision.

The block also gives an output enable. This enable drops while the control register is being rewritten, so that the serial data outputs of the engine go to high impedance. The configured mode can change from one sample to the next without a reset.

Top module: `fsw_mode_sel`

## Requirements
- R1: A synchronous active-high reset sets every channel's effective algorithm to code 00 (32 kbps) and clears every channel's substitution flag.
- R2: Algorithm codes are 00 = 32 kbps, 01 = 24 kbps, 10 = 40 kbps and 11 = reserved. A sync pulse that is high for exactly one rising clock edge, with code 00 captured, gives effective code 00 and a clear substitution flag.
- R3: A sync pulse that is high for exactly two rising clock edges, with code 00 captured, gives effective code 01 and sets the substitution flag.
- R4: A sync pulse that is high for three or more rising clock edges is treated as double-width.
- R5: When the captured code is not 00, the pulse width is ignored: the effective code equals the captured code and the substitution flag is clear.
- R6: The configuration code is captured on the clock edge at which sync is first seen high. Changes to the code later in the same pulse have no effect until the next pulse.
- R7: The effective code and the flag update only on the clock edge at which sync is first seen low after being high. They hold their values at all other times.
- R8: Each channel measures and decides on its own, with no effect from the sync input or configuration of any other channel.
- R9: While a channel's effective code is 01, its output word equals its input word with bit 0 replaced by that channel's signalling bit. Under any other code the output word equals the input word.
- R10: The output enable is low in every cycle in which the register-update input is high, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sync_i | input | NUM_CH | Frame-sync line, one per channel |
| cfg_alg_i | input | NUM_CH x 2 | Configured algorithm code per channel |
| upd_i | input | 1 | Control register update in progress |
| sig_i | input | NUM_CH | Signalling bit per channel |
| word_i | input | NUM_CH x WORD_W | Compressed code word per channel, before insertion |
| word_o | output | NUM_CH x WORD_W | Code word after signalling insertion |
| alg_o | output | NUM_CH x 2 | Effective algorithm code for the current sample |
| swap_o | output | NUM_CH | Set when 32 kbps was changed to 24 kbps by a wide pulse |
| out_en_o | output | 1 | Serial output enable, low during register updates |

## Verification
A wrong pulse-width count or a wrong captured code shows up at alg_o and swap_o one clock after the falling edge of the sync pulse that was mismeasured. Because the decision is held, the wrong value then stays visible for the whole sample. A decision register that updates at the wrong time shows up as a change of alg_o in the middle of the next pulse, and the bench checks this one clock after each rising edge of sync. Any mismatch in the effective code also shows at once in bit 0 of word_o, because the insertion logic is combinational.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
   typedef enum logic [1:0] {
      ALG_32K = 2'b00,
      ALG_24K = 2'b01,
      ALG_40K = 2'b10,
      ALG_RSV = 2'b11
   } alg_e;

   localparam int ALG_W = 2;
   localparam int WIDE_CLOCKS = 2;
endpackage

// File: rtl/fsw_width_meter.sv
module fsw_width_meter #(
   parameter int CNT_W = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic sync_i,
   output logic start_o,
   output logic end_o,
   output logic wide_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] WIDE_TH = CNT_W'(fsw_pkg::WIDE_CLOCKS);

   logic             sync_q;
   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (CNT_W >= 2) else $error("CNT_W must hold the value 2");
   end

   assign start_o = sync_i & ~sync_q;
   assign end_o   = ~sync_i & sync_q;
   assign wide_o  = (cnt_q >= WIDE_TH);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sync_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         sync_q <= sync_i;
         if (start_o) begin
            cnt_q <= CNT_W'(1);
         end else if (sync_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
      start_o |=> (cnt_q == CNT_W'(1)));                                  // R2
   AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
      (sync_i && !start_o && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));   // R4
endmodule

// File: rtl/fsw_mode_reg.sv
module fsw_mode_reg
   import fsw_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       start_i,
   input  logic       end_i,
   input  logic       wide_i,
   input  logic [1:0] cfg_i,
   output logic [1:0] alg_o,
   output logic       swap_o
);
   alg_e cfg_q;
   alg_e alg_q;
   logic swap_q;
   logic swap_d;

   assign swap_d = (cfg_q == ALG_32K) && wide_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cfg_q  <= ALG_32K;
         alg_q  <= ALG_32K;
         swap_q <= 1'b0;
      end else begin
         if (start_i) begin
            cfg_q <= alg_e'(cfg_i);
         end
         if (end_i) begin
            swap_q <= swap_d;
            alg_q  <= swap_d ? ALG_24K : cfg_q;
         end
      end
   end

   assign alg_o  = alg_q;
   assign swap_o = swap_q;

   AST_SWAP_MEANS_24K: assert property (@(posedge clk_i) disable iff (rst_i)
      swap_q |-> (alg_q == ALG_24K));                                     // R3
   AST_HOLD_OUTSIDE_END: assert property (@(posedge clk_i) disable iff (rst_i)
      !end_i |=> ($stable(alg_q) && $stable(swap_q)));                    // R7
   AST_OTHER_MODE_PASS: assert property (@(posedge clk_i) disable iff (rst_i)
      (end_i && cfg_q != ALG_32K) |=> (alg_q == $past(cfg_q) && !swap_q)); // R5
endmodule

// File: rtl/fsw_lsb_insert.sv
module fsw_lsb_insert
   import fsw_pkg::*;
#(
   parameter int WORD_W     = 4,
   parameter bit LSB_INSERT = 1'b1
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic              sig_i,
   input  logic [1:0]        alg_i,
   output logic [WORD_W-1:0] word_o
);
   generate
      if (LSB_INSERT) begin : g_insert
         always_comb begin
            word_o = word_i;
            if (alg_e'(alg_i) == ALG_24K) begin
               word_o[0] = sig_i;
            end
         end
      end else begin : g_pass
         assign word_o = word_i;
      end
   endgenerate
endmodule

// File: rtl/fsw_mode_sel.sv
module fsw_mode_sel
   import fsw_pkg::*;
#(
   parameter int NUM_CH     = 2,
   parameter int WORD_W     = 4,
   parameter int CNT_W      = 2,
   parameter bit LSB_INSERT = 1'b1
) (
   input  logic                           clk_i,
   input  logic                           rst_i,
   input  logic [NUM_CH-1:0]              sync_i,
   input  logic [NUM_CH-1:0][ALG_W-1:0]   cfg_alg_i,
   input  logic                           upd_i,
   input  logic [NUM_CH-1:0]              sig_i,
   input  logic [NUM_CH-1:0][WORD_W-1:0]  word_i,
   output logic [NUM_CH-1:0][WORD_W-1:0]  word_o,
   output logic [NUM_CH-1:0][ALG_W-1:0]   alg_o,
   output logic [NUM_CH-1:0]              swap_o,
   output logic                           out_en_o
);
   initial begin
      assert (NUM_CH >= 1) else $error("NUM_CH must be at least 1");
      assert (WORD_W >= 2) else $error("WORD_W must be at least 2");
   end

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic start_w;
         logic end_w;
         logic wide_w;

         fsw_width_meter #(.CNT_W(CNT_W)) i_meter (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .sync_i  (sync_i[ch]),
            .start_o (start_w),
            .end_o   (end_w),
            .wide_o  (wide_w)
         );

         fsw_mode_reg i_mode (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .start_i (start_w),
            .end_i   (end_w),
            .wide_i  (wide_w),
            .cfg_i   (cfg_alg_i[ch]),
            .alg_o   (alg_o[ch]),
            .swap_o  (swap_o[ch])
         );

         fsw_lsb_insert #(.WORD_W(WORD_W), .LSB_INSERT(LSB_INSERT)) i_lsb (
            .word_i  (word_i[ch]),
            .sig_i   (sig_i[ch]),
            .alg_i   (alg_o[ch]),
            .word_o  (word_o[ch])
         );

         AST_RESET_CLEARS: assert property (@(posedge clk_i)
            rst_i |=> (alg_o[ch] == ALG_32K && !swap_o[ch]));             // R1
      end
   endgenerate

   assign out_en_o = ~upd_i;
endmodule

// File: tb/test_fsw_mode_sel.sv
module test_fsw_mode_sel;
   localparam int NCH = 2;
   localparam int WW  = 4;

   logic                      clk = 1'b0;
   logic                      rst;
   logic [NCH-1:0]            sync;
   logic [NCH-1:0][1:0]       cfg;
   logic                      upd;
   logic [NCH-1:0]            sig;
   logic [NCH-1:0][WW-1:0]    wi;
   logic [NCH-1:0][WW-1:0]    wo;
   logic [NCH-1:0][1:0]       alg;
   logic [NCH-1:0]            swp;
   logic                      oe;

   int errs   = 0;
   int checks = 0;
   logic [1:0] prev_alg [NCH];
   bit         prev_swp [NCH];

   always #4 clk = ~clk;

   fsw_mode_sel #(.NUM_CH(NCH), .WORD_W(WW)) i_fsw_mode_sel (
      .clk_i(clk), .rst_i(rst), .sync_i(sync), .cfg_alg_i(cfg), .upd_i(upd),
      .sig_i(sig), .word_i(wi), .word_o(wo), .alg_o(alg), .swap_o(swp),
      .out_en_o(oe)
   );

   function automatic logic [1:0] exp_alg(input logic [1:0] c, input int w);
      return (c == 2'b00 && w >= 2) ? 2'b01 : c;
   endfunction

   function automatic bit exp_swp(input logic [1:0] c, input int w);
      return (c == 2'b00 && w >= 2);
   endfunction

   function automatic logic [WW-1:0] exp_word(input logic [1:0] a,
                                              input logic [WW-1:0] w,
                                              input logic s);
      return (a == 2'b01) ? {w[WW-1:1], s} : w;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_outputs(input string req);
      for (int ch = 0; ch < NCH; ch++) begin
         chk(alg[ch] === prev_alg[ch], req, $sformatf("alg ch%0d", ch),
             int'(alg[ch]), int'(prev_alg[ch]));
         chk(swp[ch] === prev_swp[ch], req, $sformatf("swap ch%0d", ch),
             int'(swp[ch]), int'(prev_swp[ch]));
      end
   endtask

   task automatic check_side;  // R9 word insertion, R10 output enable
      wi  = WW'($urandom);
      wi[1] = WW'($urandom);
      sig = NCH'($urandom);
      upd = 1'($urandom);
      #1;
      for (int ch = 0; ch < NCH; ch++) begin
         chk(wo[ch] === exp_word(alg[ch], wi[ch], sig[ch]), "R9",
             $sformatf("word ch%0d", ch), int'(wo[ch]),
             int'(exp_word(alg[ch], wi[ch], sig[ch])));
      end
      chk(oe === !upd, "R10", "out_en", int'(oe), int'(!upd));
      upd = 1'b0;
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int ch = 0; ch < NCH; ch++) begin
         prev_alg[ch] = 2'b00;
         prev_swp[ch] = 1'b0;
      end
      check_outputs("R1");
   endtask

   // One sample: both sync lines rise together, each stays high w[ch] edges.
   task automatic run_sample(input int w0, input int w1,
                             input logic [1:0] c0, input logic [1:0] c1,
                             input bit scramble, input string req);
      int w [NCH];
      int maxw;
      w[0] = w0;
      w[1] = w1;
      maxw = (w0 > w1) ? w0 : w1;
      @(negedge clk);
      cfg[0] = c0;
      cfg[1] = c1;
      sync = '1;
      for (int i = 1; i <= maxw; i++) begin
         @(negedge clk);
         if (i == 1) begin
            check_outputs("R7");
            if (scramble) cfg = ~cfg;  // R6: late change must not count
         end
         for (int ch = 0; ch < NCH; ch++) if (i == w[ch]) sync[ch] = 1'b0;
      end
      repeat (3) @(negedge clk);
      prev_alg[0] = exp_alg(c0, w0);
      prev_swp[0] = exp_swp(c0, w0);
      prev_alg[1] = exp_alg(c1, w1);
      prev_swp[1] = exp_swp(c1, w1);
      check_outputs(req);
      check_side();
   endtask

   initial begin
      #(8 * 150000);
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20251));
      rst = 1'b1; sync = '0; cfg = '0; upd = 1'b0; sig = '0; wi = '0;
      do_reset();                               // R1
      run_sample(1, 1, 2'b00, 2'b00, 0, "R2");
      run_sample(2, 2, 2'b00, 2'b00, 0, "R3");
      run_sample(1, 1, 2'b00, 2'b00, 0, "R2");
      run_sample(3, 4, 2'b00, 2'b00, 0, "R4");
      run_sample(2, 3, 2'b01, 2'b10, 0, "R5");
      run_sample(4, 2, 2'b11, 2'b01, 0, "R5");
      run_sample(2, 1, 2'b00, 2'b00, 1, "R6");
      run_sample(1, 2, 2'b10, 2'b11, 1, "R6");
      run_sample(1, 2, 2'b00, 2'b00, 0, "R8");
      run_sample(2, 1, 2'b00, 2'b00, 0, "R8");
      run_sample(2, 2, 2'b00, 2'b10, 0, "R8");
      run_sample(2, 2, 2'b00, 2'b00, 0, "R3");
      do_reset();                               // R1 after a substitution
      for (int n = 0; n < 200; n++) begin
         run_sample(1 + int'($urandom % 4), 1 + int'($urandom % 4),
                    2'($urandom), 2'($urandom), 1'($urandom), "R8");
      end
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule